// File: doc/BRIEF.md
# Multiplexed Pixel Palette Lookup Pipeline

This block accepts a group of four or five pixels in parallel on a slow load strobe and replays them one pixel per pixel-clock cycle. Every slot in a group carries an 8-bit palette index and a 2-bit overlay selector. The group also carries one blank flag and one sync flag that all of its pixels share. For each pixel the block looks up a 24-bit colour. The colour comes either from a 256-entry palette memory or from a small bank of overlay colour registers. The block then presents the colour as registered red, green and blue bytes, or as the blanking level.

The load strobe runs at one quarter or one fifth of the pixel rate and has no fixed phase relation to the pixel clock. A captured group is handed to the pixel-clock domain through a toggle flag that passes through two synchronizing flops. A new group is only started when the previous group has been fully emitted, so a group is never cut short. A byte-wide write port in the pixel-clock domain loads the palette, the overlay registers and a three-bit control register.

Top module: `pix_palette_mux`

## Requirements
- R1: On a rising edge of `load_clk`, all slot indices, all overlay selectors, `blank_n` and `sync_in` are captured together as one group. A later change on these inputs does not affect a group that has already been captured.
- R2: With control bit 0 clear, slots 0..3 are emitted on consecutive pixel clocks, in ascending slot order. Slot k uses bits [8k+7:8k] of `pix_addr` and bits [2k+1:2k] of `ovl_sel`. If the load edge falls midway through a pixel-clock cycle, slot 0 appears at the outputs after the fifth rising `pclk` edge that follows the load edge.
- R3: With control bit 0 set, five slots (0..4) are emitted per group, in the same order and with the same latency as in R2.
- R4: When the overlay path is not taken, `rgb_o` is the palette word at the slot index. Red is in [23:16], green in [15:8] and blue in [7:0].
- R5: When control bit 1 is set and the slot's overlay selector is nonzero, `rgb_o` is the overlay register with that number, and the palette index is ignored. When the selector is zero, or when bit 1 is clear, the palette is used.
- R6: For a group captured with `blank_n` low, every pixel shows `rgb_o` = 0, whatever the indices and selectors are. The sync flag still passes through.
- R7: `sync_o` carries the group's sync flag and is aligned cycle for cycle with that group's pixels.
- R8: With control bit 2 set, each output component keeps its upper four bits and has its lower four bits forced to zero.
- R9: A write with `wr_en` high is applied at the next `pclk` edge. `wr_tgt` selects the target: 0 = palette, 1 = overlay register `wr_addr[1:0]`, 2 = control register from `wr_data[2:0]`. `wr_comp` selects the component: 0 = red, 1 = green, 2 = blue; the value 3 is ignored. Pixels read after the write see the new value.
- R10: If no new group has arrived when the last slot of a group is emitted, the outputs go idle (`rgb_o` = 0, `sync_o` = 0). When the strobe period equals the slot count, consecutive groups are emitted with no gap.
- R11: A synchronous active-high `rst` clears the outputs, the control register and the pipeline. After reset the outputs stay idle until a group is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock |
| load_clk | input | 1 | Slow group load strobe, captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| pix_addr | input | 40 | Palette index for each slot, slot k in bits [8k+7:8k] |
| ovl_sel | input | 10 | Overlay selector for each slot, slot k in bits [2k+1:2k] |
| blank_n | input | 1 | Group blank flag, active low |
| sync_in | input | 1 | Group sync flag |
| wr_en | input | 1 | Write strobe |
| wr_tgt | input | 2 | Write target: palette, overlay or control |
| wr_addr | input | 8 | Palette index or overlay register number |
| wr_comp | input | 2 | Colour component to write |
| wr_data | input | 8 | Write data |
| rgb_o | output | 24 | Registered colour output |
| sync_o | output | 1 | Registered sync, aligned with `rgb_o` |

## Verification
A wrong slot counter or a missed hand-off shows at the ports within one group: pixels appear repeated, skipped or shifted by a cycle against the expected stream. It can also show as a group that goes idle early. A mismatch between the palette and overlay choice, or a misaligned blank or sync delay, changes `rgb_o` or `sync_o` on the very pixel it affects, five pixel clocks after that pixel's load edge. For this reason the bench compares every output cycle against a model that is aligned to the load edge, and not only the group totals.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
  localparam int ADDR_W   = 8;
  localparam int COMP_W   = 8;
  localparam int OVL_W    = 2;
  localparam int SLOT_MAX = 5;

  typedef enum logic [1:0] {
    TGT_PAL = 2'd0,
    TGT_OVL = 2'd1,
    TGT_CTL = 2'd2
  } wr_tgt_e;

  // bit 2: nibble mode, bit 1: overlay enable, bit 0: five-slot mode
  typedef struct packed {
    logic nibble;
    logic ovl_en;
    logic five;
  } ctl_t;
endpackage

// File: rtl/pal_capture.sv
`timescale 1ns/1ps
module pal_capture #(
  parameter int SLOT_MAX = pal_pkg::SLOT_MAX,
  parameter int ADDR_W   = pal_pkg::ADDR_W,
  parameter int OVL_W    = pal_pkg::OVL_W
) (
  input  logic                       load_clk,
  input  logic                       rst,
  input  logic [SLOT_MAX*ADDR_W-1:0] pix_addr,
  input  logic [SLOT_MAX*OVL_W-1:0]  ovl_sel,
  input  logic                       blank_n,
  input  logic                       sync_in,
  output logic [SLOT_MAX*ADDR_W-1:0] grp_addr,
  output logic [SLOT_MAX*OVL_W-1:0]  grp_ovl,
  output logic                       grp_blank_n,
  output logic                       grp_sync,
  output logic                       grp_tog
);
  always_ff @(posedge load_clk) begin
    if (rst) begin
      grp_addr    <= '0;
      grp_ovl     <= '0;
      grp_blank_n <= 1'b0;
      grp_sync    <= 1'b0;
      grp_tog     <= 1'b0;
    end else begin
      grp_addr    <= pix_addr;
      grp_ovl     <= ovl_sel;
      grp_blank_n <= blank_n;
      grp_sync    <= sync_in;
      grp_tog     <= ~grp_tog;
    end
  end
endmodule

// File: rtl/pal_sequencer.sv
`timescale 1ns/1ps
module pal_sequencer #(
  parameter int SLOT_MAX = pal_pkg::SLOT_MAX,
  parameter int ADDR_W   = pal_pkg::ADDR_W,
  parameter int OVL_W    = pal_pkg::OVL_W,
  localparam int CNT_W   = $clog2(SLOT_MAX)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       five,
  input  logic [SLOT_MAX*ADDR_W-1:0] grp_addr,
  input  logic [SLOT_MAX*OVL_W-1:0]  grp_ovl,
  input  logic                       grp_blank_n,
  input  logic                       grp_sync,
  input  logic                       grp_tog,
  output logic [ADDR_W-1:0]          cur_addr,
  output logic [OVL_W-1:0]           cur_ovl,
  output logic                       cur_blank_n,
  output logic                       cur_sync,
  output logic                       cur_valid,
  output logic [CNT_W-1:0]           cur_slot
);
  logic [1:0]                 tog_sync_q;
  logic                       seen_q;
  logic                       active_q;
  logic [CNT_W-1:0]           slot_q;
  logic [SLOT_MAX*ADDR_W-1:0] addr_h;
  logic [SLOT_MAX*OVL_W-1:0]  ovl_h;
  logic                       blank_n_h;
  logic                       sync_h;

  logic             new_grp;
  logic             at_last;
  logic             boundary;
  logic [CNT_W-1:0] last_slot;

  assign last_slot = five ? CNT_W'(SLOT_MAX - 1) : CNT_W'(SLOT_MAX - 2);
  assign new_grp   = tog_sync_q[1] ^ seen_q;
  assign at_last   = (slot_q == last_slot);
  assign boundary  = !active_q || at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_sync_q <= '0;
      seen_q     <= 1'b0;
      active_q   <= 1'b0;
      slot_q     <= '0;
      addr_h     <= '0;
      ovl_h      <= '0;
      blank_n_h  <= 1'b0;
      sync_h     <= 1'b0;
    end else begin
      tog_sync_q <= {tog_sync_q[0], grp_tog};
      if (boundary) begin
        slot_q <= '0;
        if (new_grp) begin
          seen_q    <= tog_sync_q[1];
          active_q  <= 1'b1;
          addr_h    <= grp_addr;
          ovl_h     <= grp_ovl;
          blank_n_h <= grp_blank_n;
          sync_h    <= grp_sync;
        end else begin
          active_q  <= 1'b0;
        end
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign cur_addr    = addr_h[slot_q*ADDR_W +: ADDR_W];
  assign cur_ovl     = ovl_h[slot_q*OVL_W +: OVL_W];
  assign cur_blank_n = blank_n_h;
  assign cur_sync    = sync_h;
  assign cur_valid   = active_q;
  assign cur_slot    = slot_q;
endmodule

// File: rtl/pal_ram.sv
`timescale 1ns/1ps
module pal_ram #(
  parameter int ADDR_W  = pal_pkg::ADDR_W,
  parameter int COMP_W  = pal_pkg::COMP_W,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int WORD_W = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_comp,
  input  logic [COMP_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [COMP_W-1:0] mem [DEPTH];
    logic [COMP_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we && wr_comp == 2'(c)) mem[wr_addr] <= wr_data;
      rd_q <= mem[rd_addr];
    end
    assign rd_data[(2-c)*COMP_W +: COMP_W] = rd_q;
  end
endmodule

// File: rtl/pal_color_out.sv
`timescale 1ns/1ps
module pal_color_out #(
  parameter int COMP_W  = pal_pkg::COMP_W,
  parameter int OVL_W   = pal_pkg::OVL_W,
  localparam int NOVL   = 1 << OVL_W,
  localparam int WORD_W = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nibble,
  input  logic              ovl_en,
  input  logic              ovl_we,
  input  logic [OVL_W-1:0]  ovl_idx,
  input  logic [1:0]        wr_comp,
  input  logic [COMP_W-1:0] wr_data,
  input  logic [OVL_W-1:0]  cur_ovl,
  input  logic              cur_blank_n,
  input  logic              cur_sync,
  input  logic              cur_valid,
  input  logic [WORD_W-1:0] pal_data,
  output logic              s1_valid,
  output logic              s1_blank_n,
  output logic [WORD_W-1:0] rgb_o,
  output logic              sync_o
);
  logic [WORD_W-1:0] ovr_q [NOVL];
  logic [OVL_W-1:0]  s1_ovl;
  logic              s1_sync;
  logic [WORD_W-1:0] pick;
  logic [WORD_W-1:0] shaped;

  for (genvar c = 0; c < 3; c++) begin : g_ovr
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < NOVL; i++) ovr_q[i][(2-c)*COMP_W +: COMP_W] <= '0;
      end else if (ovl_we && wr_comp == 2'(c)) begin
        ovr_q[ovl_idx][(2-c)*COMP_W +: COMP_W] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_blank_n <= 1'b0;
      s1_sync    <= 1'b0;
      s1_ovl     <= '0;
    end else begin
      s1_valid   <= cur_valid;
      s1_blank_n <= cur_blank_n;
      s1_sync    <= cur_sync;
      s1_ovl     <= cur_ovl;
    end
  end

  always_comb begin
    pick   = (ovl_en && s1_ovl != '0) ? ovr_q[s1_ovl] : pal_data;
    shaped = pick;
    if (nibble) begin
      for (int c = 0; c < 3; c++) shaped[c*COMP_W +: COMP_W/2] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb_o  <= '0;
      sync_o <= 1'b0;
    end else begin
      rgb_o  <= (s1_valid && s1_blank_n) ? shaped : '0;
      sync_o <= s1_valid && s1_sync;
    end
  end
endmodule

// File: rtl/pix_palette_mux.sv
`timescale 1ns/1ps
module pix_palette_mux #(
  parameter int SLOT_MAX = pal_pkg::SLOT_MAX,
  parameter int ADDR_W   = pal_pkg::ADDR_W,
  parameter int COMP_W   = pal_pkg::COMP_W,
  parameter int OVL_W    = pal_pkg::OVL_W,
  localparam int CNT_W   = $clog2(SLOT_MAX),
  localparam int WORD_W  = 3 * COMP_W
) (
  input  logic                       pclk,
  input  logic                       load_clk,
  input  logic                       rst,
  input  logic [SLOT_MAX*ADDR_W-1:0] pix_addr,
  input  logic [SLOT_MAX*OVL_W-1:0]  ovl_sel,
  input  logic                       blank_n,
  input  logic                       sync_in,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_tgt,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [1:0]                 wr_comp,
  input  logic [COMP_W-1:0]          wr_data,
  output logic [WORD_W-1:0]          rgb_o,
  output logic                       sync_o
);
  import pal_pkg::*;

  ctl_t ctl_q;

  logic [SLOT_MAX*ADDR_W-1:0] grp_addr;
  logic [SLOT_MAX*OVL_W-1:0]  grp_ovl;
  logic                       grp_blank_n, grp_sync, grp_tog;
  logic [ADDR_W-1:0]          cur_addr;
  logic [OVL_W-1:0]           cur_ovl;
  logic                       cur_blank_n, cur_sync, cur_valid;
  logic [CNT_W-1:0]           cur_slot;
  logic [WORD_W-1:0]          pal_data;
  logic                       s1_valid, s1_blank_n;
  logic                       pal_we, ovl_we;

  assign pal_we = wr_en && (wr_tgt == TGT_PAL);
  assign ovl_we = wr_en && (wr_tgt == TGT_OVL);

  always_ff @(posedge pclk) begin
    if (rst)                              ctl_q <= '0;
    else if (wr_en && wr_tgt == TGT_CTL) ctl_q <= ctl_t'(wr_data[2:0]);
  end

  pal_capture #(.SLOT_MAX(SLOT_MAX), .ADDR_W(ADDR_W), .OVL_W(OVL_W)) u_cap (
    .load_clk(load_clk), .rst(rst), .pix_addr(pix_addr), .ovl_sel(ovl_sel),
    .blank_n(blank_n), .sync_in(sync_in), .grp_addr(grp_addr), .grp_ovl(grp_ovl),
    .grp_blank_n(grp_blank_n), .grp_sync(grp_sync), .grp_tog(grp_tog)
  );

  pal_sequencer #(.SLOT_MAX(SLOT_MAX), .ADDR_W(ADDR_W), .OVL_W(OVL_W)) u_seq (
    .clk(pclk), .rst(rst), .five(ctl_q.five), .grp_addr(grp_addr), .grp_ovl(grp_ovl),
    .grp_blank_n(grp_blank_n), .grp_sync(grp_sync), .grp_tog(grp_tog),
    .cur_addr(cur_addr), .cur_ovl(cur_ovl), .cur_blank_n(cur_blank_n),
    .cur_sync(cur_sync), .cur_valid(cur_valid), .cur_slot(cur_slot)
  );

  pal_ram #(.ADDR_W(ADDR_W), .COMP_W(COMP_W)) u_ram (
    .clk(pclk), .we(pal_we), .wr_addr(wr_addr), .wr_comp(wr_comp),
    .wr_data(wr_data), .rd_addr(cur_addr), .rd_data(pal_data)
  );

  pal_color_out #(.COMP_W(COMP_W), .OVL_W(OVL_W)) u_out (
    .clk(pclk), .rst(rst), .nibble(ctl_q.nibble), .ovl_en(ctl_q.ovl_en),
    .ovl_we(ovl_we), .ovl_idx(wr_addr[OVL_W-1:0]), .wr_comp(wr_comp),
    .wr_data(wr_data), .cur_ovl(cur_ovl), .cur_blank_n(cur_blank_n),
    .cur_sync(cur_sync), .cur_valid(cur_valid), .pal_data(pal_data),
    .s1_valid(s1_valid), .s1_blank_n(s1_blank_n), .rgb_o(rgb_o), .sync_o(sync_o)
  );
endmodule

// File: rtl/pal_checker.sv
`timescale 1ns/1ps
module pal_checker #(
  parameter int SLOT_MAX = 5,
  parameter int COMP_W   = 8,
  localparam int CNT_W   = $clog2(SLOT_MAX)
) (
  input logic              clk,
  input logic              rst,
  input logic [3*COMP_W-1:0] rgb_o,
  input logic              sync_o,
  input logic              s1_valid,
  input logic              s1_blank_n,
  input logic              nib,
  input logic              five,
  input logic              active,
  input logic [CNT_W-1:0]  slot
);
  logic [CNT_W-1:0] lastc;
  assign lastc = five ? CNT_W'(SLOT_MAX - 1) : CNT_W'(SLOT_MAX - 2);

  AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_blank_n) |=> (rgb_o == '0)); // R6

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> (rgb_o == '0 && !sync_o)); // R10

  AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    nib |=> (rgb_o[COMP_W/2-1:0] == '0 &&
             rgb_o[COMP_W+COMP_W/2-1:COMP_W] == '0 &&
             rgb_o[2*COMP_W+COMP_W/2-1:2*COMP_W] == '0)); // R8

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (active && slot != lastc) |=> (slot == CNT_W'($past(slot) + 1'b1))); // R2
endmodule

bind pix_palette_mux pal_checker #(.SLOT_MAX(SLOT_MAX), .COMP_W(COMP_W)) u_chk (
  .clk(pclk), .rst(rst), .rgb_o(rgb_o), .sync_o(sync_o), .s1_valid(s1_valid),
  .s1_blank_n(s1_blank_n), .nib(ctl_q.nibble), .five(ctl_q.five),
  .active(cur_valid), .slot(cur_slot)
);

// File: tb/pix_palette_mux_bench.sv
`timescale 1ns/1ps
module pix_palette_mux_bench;
  localparam int DEPTH = 8192;

  logic        pclk = 1'b0;
  logic        load_clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] pix_addr = '0;
  logic [9:0]  ovl_sel = '0;
  logic        blank_n = 1'b1;
  logic        sync_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_tgt = '0;
  logic [7:0]  wr_addr = '0;
  logic [1:0]  wr_comp = '0;
  logic [7:0]  wr_data = '0;
  logic [23:0] rgb_o;
  logic        sync_o;

  pix_palette_mux u_pix_palette_mux (
    .pclk(pclk), .load_clk(load_clk), .rst(rst), .pix_addr(pix_addr),
    .ovl_sel(ovl_sel), .blank_n(blank_n), .sync_in(sync_in), .wr_en(wr_en),
    .wr_tgt(wr_tgt), .wr_addr(wr_addr), .wr_comp(wr_comp), .wr_data(wr_data),
    .rgb_o(rgb_o), .sync_o(sync_o)
  );

  always #2.5 pclk = ~pclk;

  int    cyc = 0;
  int    errs = 0;
  int    checks = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;

  logic [23:0] exp_rgb  [DEPTH];
  logic        exp_sync [DEPTH];
  string       exp_tag  [DEPTH];

  logic [7:0]  sh_r [256];
  logic [7:0]  sh_g [256];
  logic [7:0]  sh_b [256];
  logic [23:0] sh_ovr [4];
  bit          sh_five, sh_ovl_en, sh_nib;

  always @(posedge pclk) cyc <= cyc + 1;

  function automatic logic [23:0] exp_color(logic [7:0] a, logic [1:0] o, logic bn);
    logic [23:0] c;
    if (!bn) return 24'h0;                          // R6
    if (sh_ovl_en && o != 2'd0) c = sh_ovr[o];      // R5
    else c = {sh_r[a], sh_g[a], sh_b[a]};           // R4
    if (sh_nib) c = c & 24'hF0F0F0;                 // R8
    return c;
  endfunction

  always @(negedge pclk) begin
    if (mon_on && !done && cyc < DEPTH) begin
      checks++;
      if (rgb_o !== exp_rgb[cyc] || sync_o !== exp_sync[cyc]) begin
        errs++;
        $display("FAIL %s cycle %0d: rgb=%h sync=%b expected rgb=%h sync=%b",
                 exp_tag[cyc], cyc, rgb_o, sync_o, exp_rgb[cyc], exp_sync[cyc]);
      end
    end
  end

  always @(posedge pclk) begin
    if (cyc == 150000 && !done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] t, input logic [7:0] a, input logic [1:0] c,
                    input logic [7:0] d);
    @(posedge pclk); #1;
    wr_en = 1'b1; wr_tgt = t; wr_addr = a; wr_comp = c; wr_data = d;
    if (t == 2'd0) begin
      if (c == 2'd0) sh_r[a] = d;
      else if (c == 2'd1) sh_g[a] = d;
      else if (c == 2'd2) sh_b[a] = d;
    end else if (t == 2'd1) begin
      if (c != 2'd3) sh_ovr[a[1:0]][(2-c)*8 +: 8] = d;
    end else if (t == 2'd2) begin
      sh_five = d[0]; sh_ovl_en = d[1]; sh_nib = d[2];
    end
  endtask

  task automatic wr_end();
    @(posedge pclk); #1;
    wr_en = 1'b0;
  endtask

  // pattern: 0 random, 1 corner indices, 2 all blanked, 3 fixed index 17
  task automatic stream(input int ngrp, input int pattern, input string tag);
    int ns;
    int n;
    logic [7:0] a [5];
    logic [1:0] o [5];
    logic       bn, sy;
    ns = sh_five ? 5 : 4;
    for (int g = 0; g < ngrp; g++) begin
      @(posedge pclk); #1;
      for (int s = 0; s < 5; s++) begin
        a[s] = 8'($urandom);
        o[s] = 2'($urandom);
        if (pattern == 1) begin
          a[s] = (s % 2 == 0) ? 8'd0 : 8'd255;
          o[s] = (s == 2) ? 2'd3 : 2'd0;
        end
        if (pattern == 3) a[s] = 8'd17;
        pix_addr[s*8 +: 8] = a[s];
        ovl_sel[s*2 +: 2]  = o[s];
      end
      bn = ($urandom % 6) != 0;
      if (pattern == 2) bn = 1'b0;
      if (pattern == 1 || pattern == 3) bn = 1'b1;
      sy = 1'($urandom);
      blank_n = bn;
      sync_in = sy;
      #1.5;
      load_clk = 1'b1;
      n = cyc;
      for (int s = 0; s < ns; s++) begin
        if (n + 5 + s < DEPTH) begin
          exp_rgb[n+5+s]  = exp_color(a[s], o[s], bn);
          exp_sync[n+5+s] = sy;
          exp_tag[n+5+s]  = tag;
        end
      end
      #1;
      // R1: scramble the inputs after capture; the group must be unaffected
      pix_addr = 40'($urandom) ^ {8'($urandom), 32'($urandom)};
      ovl_sel  = 10'($urandom);
      blank_n  = ~bn;
      sync_in  = ~sy;
      #4;
      load_clk = 1'b0;
      repeat (ns - 2) @(posedge pclk);
    end
    repeat (14) @(posedge pclk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd5417);
    for (int i = 0; i < DEPTH; i++) begin
      exp_rgb[i] = 24'h0; exp_sync[i] = 1'b0; exp_tag[i] = "R10 idle";
    end
    for (int i = 0; i < 4; i++) sh_ovr[i] = 24'h0;
    sh_five = 1'b0; sh_ovl_en = 1'b0; sh_nib = 1'b0;

    repeat (2) begin
      #3 load_clk = 1'b1;
      #3 load_clk = 1'b0;
    end
    repeat (3) @(posedge pclk);
    #1 rst = 1'b0;
    for (int i = 0; i < 8; i++) exp_tag[cyc + i] = "R11 reset state";
    mon_on = 1'b1;

    // R9: load the palette and the overlay registers
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) wr(2'd0, 8'(i), 2'(c), 8'($urandom));
    for (int i = 1; i < 4; i++)
      for (int c = 0; c < 3; c++) wr(2'd1, 8'(i), 2'(c), 8'($urandom));
    wr(2'd1, 8'd2, 2'd3, 8'hAA);   // R9: component code 3 is ignored
    wr_end();

    stream(20, 0, "R1 R2 R4 R7 four-slot palette");
    stream(3, 1, "R2 R4 corner indices");
    stream(3, 2, "R6 blanked group");

    wr(2'd2, 8'd0, 2'd0, 8'h01); wr_end();
    stream(20, 0, "R3 R4 R7 five-slot palette");

    wr(2'd2, 8'd0, 2'd0, 8'h02); wr_end();
    stream(20, 0, "R5 overlay enabled four-slot");
    stream(3, 1, "R5 overlay corner");

    wr(2'd2, 8'd0, 2'd0, 8'h07); wr_end();
    stream(15, 0, "R8 R3 nibble mode");

    wr(2'd2, 8'd0, 2'd0, 8'h00); wr_end();
    wr(2'd0, 8'd17, 2'd0, 8'h5A);
    wr(2'd0, 8'd17, 2'd1, 8'hC3);
    wr(2'd0, 8'd17, 2'd2, 8'h0F);
    wr_end();
    stream(2, 3, "R9 palette rewrite");
    stream(1, 0, "R10 single group then idle");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule